// File: doc/BRIEF.md
# Paced Dual-Channel DAC Code Streamer

This block accepts pairs of output codes, one for each of two converter channels, and plays them back at a fixed cadence. Pairs enter through a valid/ready push port and wait in a first-in, first-out store. A pacing timer counts system clocks. On every expiry it takes the oldest pair and starts one 16-bit serial frame on each of two independent transmit-only serial ports. Both ports run in lockstep.

The timer runs only while there is work to do. An accepted push starts it if it is stopped and leaves it alone if it is already counting. An expiry that finds the store empty halts the timer, clears its count and sends nothing. A separate immediate port loads both serializers directly, without going through the store. The block reports a sticky flag for pushes that arrive when the store is full. It reports a second sticky flag for words that are lost because a serializer is still shifting out an earlier frame.

Top module: `dual_dac_pacer`

## Requirements
- R1: Pairs leave in the order they were pushed; the channel 0 code of a pair appears on port 0 and the channel 1 code on port 1, and both frames of a pair start in the same cycle.
- R2: `fifoLevel` equals the number of stored pairs, and `pushReady` is low exactly when `fifoLevel` equals the DEPTH parameter.
- R3: A push with `pushValid` high while `pushReady` is low sets `overflowErr`, which stays set until reset; the pair is discarded, the level is unchanged and the pair is never transmitted.
- R4: An accepted push while the timer is stopped sets `timerRunning` on the next cycle. The first frame's chip select falls exactly PERIOD_CLKS cycles after the push is sampled. Later pairs follow at intervals of exactly PERIOD_CLKS cycles.
- R5: An expiry that finds the store empty clears `timerRunning`, starts no frame and zeroes the count. For a burst of N pairs pushed into a stopped timer, `timerRunning` falls (N+1)×PERIOD_CLKS cycles after the first push. A later push again waits a full PERIOD_CLKS.
- R6: Each frame is 16 bits, MSB first, in SPI mode 0. The clock idles low, MOSI is valid at each rising SCLK edge, and SCLK toggles every SCLK_DIV system clocks. Chip select (active low) is held low for exactly 32×SCLK_DIV cycles per frame and is high between frames.
- R7: A `directValid` pulse while both serializers are idle starts frames carrying `directCode0`/`directCode1`, with chip select low from the same clock edge that samples the pulse. The store and the timer are untouched.
- R8: A direct write or a queued update that arrives while a serializer is busy sets the sticky `collisionErr`, and its word is dropped. The frame in progress completes unchanged.
- R9: After reset both chip selects are high, both SCLKs are low, the level is zero, the timer is stopped, both error flags are clear and `pushReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pushValid | input | 1 | Push request for one code pair |
| pushCode0 | input | 16 | Channel 0 code of the pushed pair |
| pushCode1 | input | 16 | Channel 1 code of the pushed pair |
| pushReady | output | 1 | Store has room for a pair |
| directValid | input | 1 | Immediate write request |
| directCode0 | input | 16 | Channel 0 code for immediate write |
| directCode1 | input | 16 | Channel 1 code for immediate write |
| dac0Sclk | output | 1 | Serial clock, port 0 |
| dac0Mosi | output | 1 | Serial data, port 0 |
| dac0CsN | output | 1 | Chip select, port 0, active low |
| dac1Sclk | output | 1 | Serial clock, port 1 |
| dac1Mosi | output | 1 | Serial data, port 1 |
| dac1CsN | output | 1 | Chip select, port 1, active low |
| timerRunning | output | 1 | Pacing timer is counting |
| fifoLevel | output | $clog2(DEPTH+1) | Number of stored pairs |
| overflowErr | output | 1 | Sticky push-into-full flag |
| collisionErr | output | 1 | Sticky busy-serializer drop flag |

## Verification
The bench builds the block with DEPTH=4, PERIOD_CLKS=40 and SCLK_DIV=1. A 32-cycle frame therefore fits inside a 40-cycle update period. Every burst length from one pair up to a full store is swept, so full and empty boundaries and the self-stopping timer are reached within a few hundred cycles. Frame contents, start cycles and durations are predicted from the push cycle and the period. A short gap between two immediate writes lands the second write inside a running frame.

// File: rtl/dac_pacer_pkg.sv
package dac_pacer_pkg;
  // Strobes issued by the control unit to the datapath each cycle
  typedef struct packed {
    logic wrEn;        // write push codes into store
    logic loadQueue;   // start both serializers from store head
    logic loadDirect;  // start both serializers from immediate codes
  } dpStrobes_t;
endpackage

// File: rtl/dac_pacer_spi_tx.sv
module dac_pacer_spi_tx #(
  parameter int CODE_W   = 16,
  parameter int SCLK_DIV = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic [CODE_W-1:0] data,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  output logic              csN
);
  localparam int DW = (SCLK_DIV > 1) ? $clog2(SCLK_DIV) : 1;
  localparam int BW = $clog2(CODE_W);

  logic [CODE_W-1:0] shReg;
  logic [BW-1:0]     bitIdx;
  logic [DW-1:0]     divCnt;
  logic              sclkR;
  logic              busyR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyR  <= 1'b0;
      sclkR  <= 1'b0;
      shReg  <= '0;
      bitIdx <= '0;
      divCnt <= '0;
    end else if (load && !busyR) begin
      busyR  <= 1'b1;
      sclkR  <= 1'b0;
      shReg  <= data;
      bitIdx <= '0;
      divCnt <= '0;
    end else if (busyR) begin
      if (divCnt == DW'(SCLK_DIV - 1)) begin
        divCnt <= '0;
        sclkR  <= ~sclkR;
        if (sclkR) begin
          // falling edge: advance to next bit or close the frame
          if (bitIdx == BW'(CODE_W - 1)) begin
            busyR <= 1'b0;
          end else begin
            shReg  <= {shReg[CODE_W-2:0], 1'b0};
            bitIdx <= bitIdx + 1'b1;
          end
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign busy = busyR;
  assign sclk = sclkR;
  assign mosi = shReg[CODE_W-1];
  assign csN  = ~busyR;
endmodule

// File: rtl/dac_pacer_ctrl.sv
module dac_pacer_ctrl
  import dac_pacer_pkg::*;
#(
  parameter int DEPTH       = 32,
  parameter int PERIOD_CLKS = 100,
  parameter int CH          = 2,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pushValid,
  input  logic          directValid,
  input  logic [CH-1:0] chanBusy,
  output dpStrobes_t    strobes,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          pushReady,
  output logic [LW-1:0] level,
  output logic          timerRunning,
  output logic          overflowErr,
  output logic          collisionErr
);
  localparam int TW = (PERIOD_CLKS > 1) ? $clog2(PERIOD_CLKS) : 1;

  logic [TW-1:0] tmrCnt;
  logic          runR;
  logic [LW-1:0] levelR;
  logic [AW-1:0] wrPtr, rdPtr;
  logic          pushAcc, tick, storeEmpty, pop, anyBusy, collide;

  assign pushReady  = (levelR != LW'(DEPTH));
  assign pushAcc    = pushValid && pushReady;
  assign storeEmpty = (levelR == '0);
  assign tick       = runR && (tmrCnt == TW'(PERIOD_CLKS - 1));
  assign pop        = tick && !storeEmpty;
  assign anyBusy    = |chanBusy;
  assign collide    = (pop && anyBusy) || (directValid && (anyBusy || pop));

  always_comb begin
    strobes.wrEn       = pushAcc;
    strobes.loadQueue  = pop && !anyBusy;
    strobes.loadDirect = directValid && !anyBusy && !pop;
  end

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // pacing timer: runs only while work remains
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrCnt <= '0;
      runR   <= 1'b0;
    end else if (tick) begin
      tmrCnt <= '0;
      if (storeEmpty) runR <= pushAcc;
    end else if (runR) begin
      tmrCnt <= tmrCnt + 1'b1;
    end else if (pushAcc) begin
      runR   <= 1'b1;
      tmrCnt <= '0;
    end
  end

  // store bookkeeping
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      levelR <= '0;
    end else begin
      if (pushAcc) wrPtr <= nextPtr(wrPtr);
      if (pop)     rdPtr <= nextPtr(rdPtr);
      case ({pushAcc, pop})
        2'b10:   levelR <= levelR + 1'b1;
        2'b01:   levelR <= levelR - 1'b1;
        default: levelR <= levelR;
      endcase
    end
  end

  // sticky error flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overflowErr  <= 1'b0;
      collisionErr <= 1'b0;
    end else begin
      if (pushValid && !pushReady) overflowErr  <= 1'b1;
      if (collide)                 collisionErr <= 1'b1;
    end
  end

  assign wrAddr       = wrPtr;
  assign rdAddr       = rdPtr;
  assign level        = levelR;
  assign timerRunning = runR;
endmodule

// File: rtl/dac_pacer_dp.sv
module dac_pacer_dp
  import dac_pacer_pkg::*;
#(
  parameter int CODE_W   = 16,
  parameter int DEPTH    = 32,
  parameter int SCLK_DIV = 2,
  parameter int CH       = 2,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpStrobes_t                 strobes,
  input  logic [AW-1:0]              wrAddr,
  input  logic [AW-1:0]              rdAddr,
  input  logic [CH-1:0][CODE_W-1:0]  pushCodes,
  input  logic [CH-1:0][CODE_W-1:0]  directCodes,
  output logic [CH-1:0]              chanBusy,
  output logic [CH-1:0]              sclk,
  output logic [CH-1:0]              mosi,
  output logic [CH-1:0]              csN
);
  logic [CH-1:0][CODE_W-1:0] store [DEPTH];
  logic [CH-1:0][CODE_W-1:0] headCodes;
  logic [CH-1:0][CODE_W-1:0] loadCodes;
  logic                      loadAny;

  always_ff @(posedge clk) begin
    if (strobes.wrEn) store[wrAddr] <= pushCodes;
  end

  assign headCodes = store[rdAddr];
  assign loadCodes = strobes.loadDirect ? directCodes : headCodes;
  assign loadAny   = strobes.loadQueue || strobes.loadDirect;

  for (genvar c = 0; c < CH; c++) begin : g_chan
    dac_pacer_spi_tx #(
      .CODE_W  (CODE_W),
      .SCLK_DIV(SCLK_DIV)
    ) u_tx (
      .clk (clk),
      .rstN(rstN),
      .load(loadAny),
      .data(loadCodes[c]),
      .busy(chanBusy[c]),
      .sclk(sclk[c]),
      .mosi(mosi[c]),
      .csN (csN[c])
    );
  end
endmodule

// File: rtl/dual_dac_pacer.sv
module dual_dac_pacer
  import dac_pacer_pkg::*;
#(
  parameter int DEPTH       = 32,
  parameter int PERIOD_CLKS = 100,
  parameter int SCLK_DIV    = 2,
  localparam int CODE_W = 16,
  localparam int LW     = $clog2(DEPTH + 1),
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushValid,
  input  logic [CODE_W-1:0] pushCode0,
  input  logic [CODE_W-1:0] pushCode1,
  output logic              pushReady,
  input  logic              directValid,
  input  logic [CODE_W-1:0] directCode0,
  input  logic [CODE_W-1:0] directCode1,
  output logic              dac0Sclk,
  output logic              dac0Mosi,
  output logic              dac0CsN,
  output logic              dac1Sclk,
  output logic              dac1Mosi,
  output logic              dac1CsN,
  output logic              timerRunning,
  output logic [LW-1:0]     fifoLevel,
  output logic              overflowErr,
  output logic              collisionErr
);
  dpStrobes_t    strobes;
  logic [AW-1:0] wrAddr, rdAddr;
  logic [1:0]    chanBusy, sclkV, mosiV, csNV;

  dac_pacer_ctrl #(
    .DEPTH      (DEPTH),
    .PERIOD_CLKS(PERIOD_CLKS),
    .CH         (2)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .pushValid   (pushValid),
    .directValid (directValid),
    .chanBusy    (chanBusy),
    .strobes     (strobes),
    .wrAddr      (wrAddr),
    .rdAddr      (rdAddr),
    .pushReady   (pushReady),
    .level       (fifoLevel),
    .timerRunning(timerRunning),
    .overflowErr (overflowErr),
    .collisionErr(collisionErr)
  );

  dac_pacer_dp #(
    .CODE_W  (CODE_W),
    .DEPTH   (DEPTH),
    .SCLK_DIV(SCLK_DIV),
    .CH      (2)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .wrAddr     (wrAddr),
    .rdAddr     (rdAddr),
    .pushCodes  ({pushCode1, pushCode0}),
    .directCodes({directCode1, directCode0}),
    .chanBusy   (chanBusy),
    .sclk       (sclkV),
    .mosi       (mosiV),
    .csN        (csNV)
  );

  assign dac0Sclk = sclkV[0];
  assign dac0Mosi = mosiV[0];
  assign dac0CsN  = csNV[0];
  assign dac1Sclk = sclkV[1];
  assign dac1Mosi = mosiV[1];
  assign dac1CsN  = csNV[1];
endmodule

// File: rtl/dac_pacer_chk.sv
module dac_pacer_chk #(
  parameter int DEPTH = 32,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          pushValid,
  input logic          pushReady,
  input logic          directValid,
  input logic          dac0Sclk,
  input logic          dac0CsN,
  input logic          dac1Sclk,
  input logic          dac1CsN,
  input logic          timerRunning,
  input logic [LW-1:0] fifoLevel,
  input logic          overflowErr,
  input logic          collisionErr
);
  assert_ready_full_R2: assert property (@(posedge clk) disable iff (!rstN)
    (fifoLevel == LW'(DEPTH)) == !pushReady);

  assert_overflow_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && !pushReady) |=> overflowErr);

  assert_overflow_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    overflowErr |=> overflowErr);

  assert_overflow_level_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && !pushReady) |=> (fifoLevel <= $past(fifoLevel)));

  assert_push_starts_timer_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && pushReady) |=> timerRunning);

  assert_stop_only_empty_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(timerRunning) |-> (fifoLevel == '0));

  assert_lockstep_R6: assert property (@(posedge clk) disable iff (!rstN)
    (dac0CsN == dac1CsN) && (dac0Sclk == dac1Sclk));

  assert_sclk_idle_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    dac0CsN |-> !dac0Sclk);

  assert_direct_keeps_level_R7: assert property (@(posedge clk) disable iff (!rstN)
    (directValid && !pushValid && !timerRunning) |=> $stable(fifoLevel));

  assert_collision_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    collisionErr |=> collisionErr);

  assert_direct_busy_collides_R8: assert property (@(posedge clk) disable iff (!rstN)
    (directValid && !dac0CsN) |=> collisionErr);
endmodule

bind dual_dac_pacer dac_pacer_chk #(.DEPTH(DEPTH)) u_dac_pacer_chk (
  .clk         (clk),
  .rstN        (rstN),
  .pushValid   (pushValid),
  .pushReady   (pushReady),
  .directValid (directValid),
  .dac0Sclk    (dac0Sclk),
  .dac0CsN     (dac0CsN),
  .dac1Sclk    (dac1Sclk),
  .dac1CsN     (dac1CsN),
  .timerRunning(timerRunning),
  .fifoLevel   (fifoLevel),
  .overflowErr (overflowErr),
  .collisionErr(collisionErr)
);

// File: tb/test_dual_dac_pacer.sv
module test_dual_dac_pacer;
  localparam int DEPTH    = 4;
  localparam int PERIOD   = 40;
  localparam int SDIV     = 1;
  localparam int FRAMELEN = 32 * SDIV;
  localparam int LW       = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushValid = 1'b0, directValid = 1'b0;
  logic [15:0] pushCode0 = '0, pushCode1 = '0, directCode0 = '0, directCode1 = '0;
  logic pushReady, timerRunning, overflowErr, collisionErr;
  logic dac0Sclk, dac0Mosi, dac0CsN, dac1Sclk, dac1Mosi, dac1CsN;
  logic [LW-1:0] fifoLevel;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dual_dac_pacer #(.DEPTH(DEPTH), .PERIOD_CLKS(PERIOD), .SCLK_DIV(SDIV)) i_dual_dac_pacer (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushCode0(pushCode0),
    .pushCode1(pushCode1), .pushReady(pushReady), .directValid(directValid),
    .directCode0(directCode0), .directCode1(directCode1),
    .dac0Sclk(dac0Sclk), .dac0Mosi(dac0Mosi), .dac0CsN(dac0CsN),
    .dac1Sclk(dac1Sclk), .dac1Mosi(dac1Mosi), .dac1CsN(dac1CsN),
    .timerRunning(timerRunning), .fifoLevel(fifoLevel),
    .overflowErr(overflowErr), .collisionErr(collisionErr));

  // serial port monitor: frames captured on the SCLK rising edge
  logic [15:0] frData [2][64];
  int frStart [2][64];
  int frEnd [2][64];
  int frBits [2][64];
  int frCount [2];
  logic [15:0] shIn [2];
  int bitsIn [2], curStart [2];
  logic [1:0] prevCsN = 2'b11, prevSclk = 2'b00;

  always @(negedge clk) begin
    logic [1:0] csV, skV, moV;
    csV = {dac1CsN, dac0CsN};
    skV = {dac1Sclk, dac0Sclk};
    moV = {dac1Mosi, dac0Mosi};
    for (int ch = 0; ch < 2; ch++) begin
      if (prevCsN[ch] === 1'b1 && csV[ch] === 1'b0) begin
        curStart[ch] = cyc; shIn[ch] = '0; bitsIn[ch] = 0;
      end
      if (csV[ch] === 1'b0 && skV[ch] === 1'b1 && prevSclk[ch] === 1'b0) begin
        shIn[ch] = {shIn[ch][14:0], moV[ch]}; bitsIn[ch]++;
      end
      if (prevCsN[ch] === 1'b0 && csV[ch] === 1'b1 && frCount[ch] < 64) begin
        frData[ch][frCount[ch]]  = shIn[ch];
        frStart[ch][frCount[ch]] = curStart[ch];
        frEnd[ch][frCount[ch]]   = cyc;
        frBits[ch][frCount[ch]]  = bitsIn[ch];
        frCount[ch]++;
      end
    end
    prevCsN  = csV;
    prevSclk = skV;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] codeOf(int ch, int n, int k);
    return 16'((n * 4099 + k * 1237 + ch * 30001) ^ 16'hA55A);
  endfunction

  task automatic doPush(input logic [15:0] c0, input logic [15:0] c1, output int at);
    @(negedge clk);
    pushValid = 1'b1; pushCode0 = c0; pushCode1 = c1;
    @(negedge clk);
    at = cyc;
    pushValid = 1'b0;
  endtask

  task automatic doDirect(input logic [15:0] c0, input logic [15:0] c1, output int at);
    @(negedge clk);
    directValid = 1'b1; directCode0 = c0; directCode1 = c1;
    @(negedge clk);
    at = cyc;
    directValid = 1'b0;
  endtask

  task automatic clearMon();
    @(negedge clk);
    frCount[0] = 0; frCount[1] = 0;
  endtask

  // waits for the timer to stop; returns the cycle it was first seen low
  task automatic waitStop(input int limit, output int at);
    at = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (!timerRunning) begin at = cyc; break; end
    end
  endtask

  task automatic checkFrames(input int n, input int first, input int nIdx, input string req);
    check(frCount[0] == n && frCount[1] == n, req, "frame count", frCount[0], n);
    for (int k = 0; k < n && k < frCount[0] && k < frCount[1]; k++) begin
      for (int ch = 0; ch < 2; ch++) begin
        check(frData[ch][k] == codeOf(ch, nIdx, k), "R1", "frame data order",
              frData[ch][k], codeOf(ch, nIdx, k));
        check(frStart[ch][k] == first + PERIOD * (k + 1), "R4", "frame start cycle",
              frStart[ch][k], first + PERIOD * (k + 1));
        check(frBits[ch][k] == 16, "R6", "rising edges per frame", frBits[ch][k], 16);
        check(frEnd[ch][k] - frStart[ch][k] == FRAMELEN, "R6", "chip select low span",
              frEnd[ch][k] - frStart[ch][k], FRAMELEN);
      end
      check(frStart[0][k] == frStart[1][k], "R1", "pair frames start together",
            frStart[1][k], frStart[0][k]);
    end
  endtask

  initial begin
    int first, tmp, stopAt, dAt;
    frCount[0] = 0; frCount[1] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(dac0CsN && dac1CsN, "R9", "chip selects high", {dac1CsN, dac0CsN}, 3);
    check(!dac0Sclk && !dac1Sclk, "R9", "sclk low", {dac1Sclk, dac0Sclk}, 0);
    check(fifoLevel == 0, "R9", "level", fifoLevel, 0);
    check(!timerRunning, "R9", "timer stopped", timerRunning, 0);
    check(!overflowErr && !collisionErr, "R9", "flags clear",
          {overflowErr, collisionErr}, 0);
    check(pushReady, "R9", "pushReady", pushReady, 1);

    // burst sweep: every length from one pair to a full store
    for (int n = 1; n <= DEPTH; n++) begin
      clearMon();
      for (int k = 0; k < n; k++) begin
        doPush(codeOf(0, n, k), codeOf(1, n, k), tmp);
        if (k == 0) begin
          first = tmp;
          check(timerRunning, "R4", "timer starts on push", timerRunning, 1);
        end
      end
      check(fifoLevel == LW'(n), "R2", "level after burst", fifoLevel, n);
      check(pushReady == (n < DEPTH), "R2", "pushReady vs level", pushReady, n < DEPTH);
      waitStop((n + 3) * PERIOD, stopAt);
      check(stopAt == first + PERIOD * (n + 1), "R5", "timer stop cycle",
            stopAt, first + PERIOD * (n + 1));
      check(fifoLevel == 0, "R5", "drained level", fifoLevel, 0);
      repeat (PERIOD + 4) @(negedge clk);
      check(frCount[0] == n, "R5", "no frame from empty expiry", frCount[0], n);
      checkFrames(n, first, n, "R1");
    end
    check(!overflowErr && !collisionErr, "R3", "no false error flags",
          {overflowErr, collisionErr}, 0);

    // overflow: fill the store, then push once more
    clearMon();
    for (int k = 0; k < DEPTH; k++) begin
      doPush(codeOf(0, 9, k), codeOf(1, 9, k), tmp);
      if (k == 0) first = tmp;
    end
    doPush(16'hDEAD, 16'hBEEF, tmp);
    check(overflowErr, "R3", "overflow flag set", overflowErr, 1);
    check(fifoLevel == LW'(DEPTH), "R3", "level unchanged on overflow", fifoLevel, DEPTH);
    waitStop((DEPTH + 3) * PERIOD, stopAt);
    repeat (4) @(negedge clk);
    checkFrames(DEPTH, first, 9, "R3");
    check(overflowErr, "R3", "overflow flag sticky", overflowErr, 1);

    // direct write while idle
    clearMon();
    doDirect(16'h8001, 16'h7FFE, dAt);
    check(fifoLevel == 0 && !timerRunning, "R7", "store and timer untouched",
          {timerRunning, fifoLevel}, 0);
    repeat (FRAMELEN + 4) @(negedge clk);
    check(frCount[0] == 1 && frCount[1] == 1, "R7", "one direct frame", frCount[0], 1);
    check(frStart[0][0] == dAt, "R7", "direct start cycle", frStart[0][0], dAt);
    check(frData[0][0] == 16'h8001, "R7", "direct data ch0", frData[0][0], 16'h8001);
    check(frData[1][0] == 16'h7FFE, "R7", "direct data ch1", frData[1][0], 16'h7FFE);
    check(!collisionErr, "R8", "no collision when idle", collisionErr, 0);

    // direct write into a busy serializer
    clearMon();
    doDirect(16'h0F0F, 16'hF0F0, dAt);
    repeat (5) @(negedge clk);
    doDirect(16'hFFFF, 16'h0000, tmp);
    check(collisionErr, "R8", "collision flag set", collisionErr, 1);
    repeat (FRAMELEN + 8) @(negedge clk);
    check(frCount[0] == 1, "R8", "colliding word dropped", frCount[0], 1);
    check(frData[0][0] == 16'h0F0F, "R8", "frame in progress intact", frData[0][0], 16'h0F0F);
    check(frData[1][0] == 16'hF0F0, "R8", "frame in progress intact ch1",
          frData[1][0], 16'hF0F0);
    check(collisionErr, "R8", "collision flag sticky", collisionErr, 1);

    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule